// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Controller

This block keeps an attached DDR2 SDRAM refreshed and manages its low-power state. Software programs a single 32-bit control word that holds a refresh interval, a self-refresh request and a permission to stop the memory clock. The block counts controller clocks and raises one autorefresh request per interval toward a command scheduler over a request/acknowledge handshake. Refreshes that the scheduler has not yet taken are counted and then issued back to back.

When software asks for self-refresh, the block first lets every owed refresh go out. It then hands a self-refresh-enter request to the scheduler and, once that request is acknowledged and clock stopping is allowed, drops the memory clock enable. On the way out it restores the clock, waits a fixed settling time, issues a self-refresh-exit request, and follows the exit with one immediate autorefresh. The tRFC timing value arrives on an input and serves as a lower bound when software programs an interval that is too short.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0884: interval field (bits 15:0) = 0x0884, self-refresh bit (bit 31) = 0, clock-stop bit (bit 30) = 0; the memory clock enable is 1 and no request is raised.
- R2: A write whose bits 15:0 are below 0x0100 loads the interval field with 2 × trfc; a value of 0x0100 or above is loaded unchanged.
- R3: Reads return the self-refresh bit at 31, the clock-stop bit at 30 and the interval at 15:0; bits 29:16, including bit 23, read 0 whatever was written.
- R4: In normal operation an autorefresh request is raised once every interval-field clock cycles; a write of the control word restarts the count, so the next request rises interval + 1 cycles after the write cycle.
- R5: ref_req stays high until ref_ack is seen with it; refresh intervals that expire before acknowledgement are counted up to 8, and the owed refreshes are issued on consecutive cycles when acknowledged at once.
- R6: A write sets the clock-stop bit only if the self-refresh bit was already 1 before that write; otherwise the bit reads 0.
- R7: After the self-refresh bit is set, sr_enter_req rises only when no refresh is owed and is held until sr_enter_ack; while in self-refresh no autorefresh request is raised.
- R8: mclk_en goes low only after sr_enter_ack has been taken and only while the clock-stop bit is 1.
- R9: After the self-refresh bit is cleared, mclk_en returns high first, sr_exit_req rises 16 cycles later and is held until sr_exit_ack, and ref_req is high in the cycle right after the exit acknowledgement.
- R10: Clearing the clock-stop bit while in self-refresh raises mclk_en without leaving self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| trfc | input | 8 | tRFC value in controller cycles |
| ref_req | output | 1 | Autorefresh request |
| ref_ack | input | 1 | Autorefresh accepted |
| sr_enter_req | output | 1 | Self-refresh entry request |
| sr_enter_ack | input | 1 | Self-refresh entry accepted |
| sr_exit_req | output | 1 | Self-refresh exit request |
| sr_exit_ack | input | 1 | Self-refresh exit accepted |
| mclk_en | output | 1 | Memory clock enable |

## Verification
The assertions take for granted that each acknowledge is a single-cycle pulse given only while its request is high, and that the scheduler never acknowledges an entry or exit request that is not shown. The bench drives every acknowledge from its own model's view of the request, with per-handshake latencies and an optional hold-off on refresh acknowledgements, so acknowledges never appear unprompted. Writes to the control word are single-cycle strobes, and the tRFC input is changed only between writes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int CSR_W    = 32;
    localparam int IVL_W    = 16;
    localparam int SR_POS   = 31;
    localparam int STOP_POS = 30;

    localparam logic [IVL_W-1:0] IVL_RESET = 16'h0884;
    localparam logic [IVL_W-1:0] IVL_FLOOR = 16'h0100;

    typedef enum logic [2:0] {
        LP_RUN,
        LP_DRAIN,
        LP_SRE,
        LP_SRIN,
        LP_WAKE,
        LP_SRX
    } lp_state_e;

    typedef struct packed {
        logic             sr;
        logic             stop;
        logic [IVL_W-1:0] ivl;
    } rfsh_cfg_t;

    function automatic logic [IVL_W-1:0] floor_interval(
        input logic [IVL_W-1:0] asked,
        input logic [IVL_W-1:0] trfc_x2
    );
        return (asked < IVL_FLOOR) ? trfc_x2 : asked;
    endfunction

    function automatic logic [CSR_W-1:0] csr_image(input rfsh_cfg_t c);
        logic [CSR_W-1:0] v;
        v               = '0;
        v[SR_POS]       = c.sr;
        v[STOP_POS]     = c.stop;
        v[IVL_W-1:0]    = c.ivl;
        return v;
    endfunction

endpackage

// File: rtl/rfsh_csr.sv
module rfsh_csr
    import rfsh_pkg::*;
#(
    parameter int TRFC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic [TRFC_W-1:0] trfc,
    output rfsh_cfg_t        cfg,
    output logic [IVL_W-1:0] load_val,
    output logic [CSR_W-1:0] rdata
);

    logic [IVL_W-1:0] trfc_x2;
    logic             unused_bits;

    assign trfc_x2     = IVL_W'(trfc) << 1;
    assign unused_bits = ^wdata[STOP_POS-1:IVL_W];
    assign load_val    = floor_interval(wdata[IVL_W-1:0], trfc_x2);
    assign rdata       = csr_image(cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.sr   <= 1'b0;
            cfg.stop <= 1'b0;
            cfg.ivl  <= IVL_RESET;
        end else if (we) begin
            cfg.sr   <= wdata[SR_POS];
            cfg.stop <= wdata[STOP_POS] & cfg.sr;
            cfg.ivl  <= load_val;
        end
    end

    AST_FLOOR_APPLIED: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(we)) |-> (cfg.ivl >= IVL_FLOOR || cfg.ivl == $past(trfc_x2))); // R2
    AST_STOP_NEEDS_SR: assert property (@(posedge clk) disable iff (rst) $rose(cfg.stop) |-> $past(cfg.sr)); // R6

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer
    import rfsh_pkg::*;
#(
    parameter int PEND_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IVL_W-1:0] ivl,
    input  logic [IVL_W-1:0] load_val,
    input  logic             load,
    input  logic             run,
    input  logic             allow,
    input  logic             restart,
    input  logic             ref_ack,
    output logic             ref_req,
    output logic             pend_zero
);

    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] PEND_TOP = PW'(PEND_MAX);

    logic [IVL_W-1:0] cnt;
    logic [PW-1:0]    pend;
    logic             tick;
    logic             take;

    assign tick      = run && !load && (cnt < IVL_W'(2));
    assign take      = ref_req && ref_ack;
    assign pend_zero = (pend == '0);
    assign ref_req   = allow && !pend_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= IVL_RESET;
        end else if (load) begin
            cnt <= load_val;
        end else if (restart) begin
            cnt <= ivl;
        end else if (run) begin
            cnt <= (cnt < IVL_W'(2)) ? ivl : cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (restart) begin
            pend <= PW'(1);
        end else if (tick && !take && pend != PEND_TOP) begin
            pend <= pend + 1'b1;
        end else if (!tick && take) begin
            pend <= pend - 1'b1;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) (ref_req && !ref_ack) |=> ref_req); // R5
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst) (!run && !load && !restart) |=> $stable(cnt)); // R7

endmodule

// File: rtl/rfsh_lpseq.sv
module rfsh_lpseq
    import rfsh_pkg::*;
#(
    parameter int WAKE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sr,
    input  logic stop,
    input  logic pend_zero,
    input  logic sre_ack,
    input  logic srx_ack,
    output logic run,
    output logic allow,
    output logic restart,
    output logic sre_req,
    output logic srx_req,
    output logic mclk_en
);

    localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

    lp_state_e      st, st_nx;
    logic [WW-1:0]  wc;

    always_comb begin
        st_nx = st;
        unique case (st)
            LP_RUN:   if (sr) st_nx = LP_DRAIN;
            LP_DRAIN: begin
                if (!sr)            st_nx = LP_RUN;
                else if (pend_zero) st_nx = LP_SRE;
            end
            LP_SRE:   if (sre_ack) st_nx = LP_SRIN;
            LP_SRIN:  if (!sr) st_nx = LP_WAKE;
            LP_WAKE:  if (wc == '0) st_nx = LP_SRX;
            LP_SRX:   if (srx_ack) st_nx = LP_RUN;
            default:  st_nx = LP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= LP_RUN;
            wc <= '0;
        end else begin
            st <= st_nx;
            if (st == LP_SRIN)
                wc <= WW'(WAKE_CYC - 1);
            else if (st == LP_WAKE && wc != '0)
                wc <= wc - 1'b1;
        end
    end

    assign run     = (st == LP_RUN);
    assign allow   = (st == LP_RUN) || (st == LP_DRAIN);
    assign sre_req = (st == LP_SRE);
    assign srx_req = (st == LP_SRX);
    assign restart = (st == LP_SRX) && srx_ack;
    assign mclk_en = !((st == LP_SRIN) && stop);

    AST_SRE_HOLD: assert property (@(posedge clk) disable iff (rst) (sre_req && !sre_ack) |=> sre_req); // R7
    AST_SRX_HOLD: assert property (@(posedge clk) disable iff (rst) (srx_req && !srx_ack) |=> srx_req); // R9

endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
    import rfsh_pkg::*;
#(
    parameter int TRFC_W   = 8,
    parameter int PEND_MAX = 8,
    parameter int WAKE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [TRFC_W-1:0] trfc,
    output logic              ref_req,
    input  logic              ref_ack,
    output logic              sr_enter_req,
    input  logic              sr_enter_ack,
    output logic              sr_exit_req,
    input  logic              sr_exit_ack,
    output logic              mclk_en
);

    rfsh_cfg_t        cfg;
    logic [IVL_W-1:0] load_val;
    logic             run, allow, restart, pend_zero;

    rfsh_csr #(.TRFC_W(TRFC_W)) u_csr (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .trfc     (trfc),
        .cfg      (cfg),
        .load_val (load_val),
        .rdata    (cfg_rdata)
    );

    rfsh_timer #(.PEND_MAX(PEND_MAX)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .ivl       (cfg.ivl),
        .load_val  (load_val),
        .load      (cfg_we),
        .run       (run),
        .allow     (allow),
        .restart   (restart),
        .ref_ack   (ref_ack),
        .ref_req   (ref_req),
        .pend_zero (pend_zero)
    );

    rfsh_lpseq #(.WAKE_CYC(WAKE_CYC)) u_lpseq (
        .clk       (clk),
        .rst       (rst),
        .sr        (cfg.sr),
        .stop      (cfg.stop),
        .pend_zero (pend_zero),
        .sre_ack   (sr_enter_ack),
        .srx_ack   (sr_exit_ack),
        .run       (run),
        .allow     (allow),
        .restart   (restart),
        .sre_req   (sr_enter_req),
        .srx_req   (sr_exit_req),
        .mclk_en   (mclk_en)
    );

    AST_ENTRY_DRAINED: assert property (@(posedge clk) disable iff (rst) sr_enter_req |-> !ref_req); // R7
    AST_CLK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) !mclk_en |-> (!ref_req && !sr_enter_req && !sr_exit_req)); // R8
    AST_EXIT_REFRESH: assert property (@(posedge clk) disable iff (rst) $fell(sr_exit_req) |-> ref_req); // R9

endmodule

// File: tb/tb_sdram_refresh_ctrl.sv
module tb_sdram_refresh_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  trfc = 8'h40;
    logic        ref_req, ref_ack = 1'b0;
    logic        sr_enter_req, sr_enter_ack = 1'b0;
    logic        sr_exit_req, sr_exit_ack = 1'b0;
    logic        mclk_en;

    always #5 clk = ~clk;

    sdram_refresh_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .trfc(trfc), .ref_req(ref_req), .ref_ack(ref_ack),
        .sr_enter_req(sr_enter_req), .sr_enter_ack(sr_enter_ack),
        .sr_exit_req(sr_exit_req), .sr_exit_ack(sr_exit_ack), .mclk_en(mclk_en)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // behavioural reference: state 0 run,1 drain,2 enter,3 in,4 wake,5 exit
    int m_int, m_sr, m_stop, m_cnt, m_pend, m_st, m_wc;
    int m_tick, m_take, m_xdone, m_lv, m_nst;
    logic        m_ref, m_sre, m_srx, m_cke;
    logic [31:0] m_rd;
    assign m_ref = (m_pend > 0) && (m_st <= 1);
    assign m_sre = (m_st == 2);
    assign m_srx = (m_st == 5);
    assign m_cke = !(m_st == 3 && m_stop == 1);
    assign m_rd  = {m_sr[0], m_stop[0], 14'h0, m_int[15:0]};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_int = 'h884; m_sr = 0; m_stop = 0; m_cnt = 'h884;
            m_pend = 0; m_st = 0; m_wc = 0;
        end else begin
            m_tick  = (m_st == 0 && m_cnt <= 1 && !cfg_we) ? 1 : 0;
            m_take  = (m_ref && ref_ack) ? 1 : 0;
            m_xdone = (m_st == 5 && sr_exit_ack) ? 1 : 0;
            m_lv    = (cfg_wdata[15:0] < 16'h0100) ? 2 * int'(trfc) : int'(cfg_wdata[15:0]);
            m_nst   = m_st;
            case (m_st)
                0: if (m_sr == 1) m_nst = 1;
                1: if (m_sr == 0) m_nst = 0; else if (m_pend == 0) m_nst = 2;
                2: if (sr_enter_ack) m_nst = 3;
                3: begin m_wc = 15; if (m_sr == 0) m_nst = 4; end
                4: if (m_wc == 0) m_nst = 5; else m_wc = m_wc - 1;
                5: if (sr_exit_ack) m_nst = 0;
                default: m_nst = 0;
            endcase
            if (cfg_we) m_cnt = m_lv;
            else if (m_xdone == 1) m_cnt = m_int;
            else if (m_st == 0) m_cnt = (m_cnt <= 1) ? m_int : m_cnt - 1;
            if (m_xdone == 1) m_pend = 1;
            else begin
                m_pend = m_pend + m_tick - m_take;
                if (m_pend > 8) m_pend = 8;
            end
            if (cfg_we) begin
                m_stop = (cfg_wdata[30] && m_sr == 1) ? 1 : 0;
                m_sr   = cfg_wdata[31] ? 1 : 0;
                m_int  = m_lv;
            end
            m_st = m_nst;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(ref_req === m_ref, "R5 ref_req vs model", 32'(ref_req), 32'(m_ref));
            chk(sr_enter_req === m_sre, "R7 sr_enter_req vs model", 32'(sr_enter_req), 32'(m_sre));
            chk(sr_exit_req === m_srx, "R9 sr_exit_req vs model", 32'(sr_exit_req), 32'(m_srx));
            chk(mclk_en === m_cke, "R8 mclk_en vs model", 32'(mclk_en), 32'(m_cke));
            chk(cfg_rdata === m_rd, "R3 cfg_rdata vs model", cfg_rdata, m_rd);
        end
    end

    // scheduler responder
    int  ref_lat = 2, sr_lat = 3, rc = 0, sc = 0, acc = 0;
    bit  ref_block = 0;
    logic prev_req = 1'b0;
    always @(negedge clk) begin
        if (prev_req && ref_ack) acc++;
        prev_req = ref_req;
        if (rst) begin
            ref_ack <= 0; sr_enter_ack <= 0; sr_exit_ack <= 0; rc <= 0; sc <= 0;
        end else begin
            if (m_ref && !ref_block) begin
                if (rc >= ref_lat) begin ref_ack <= 1; rc <= 0; end
                else begin ref_ack <= 0; rc <= rc + 1; end
            end else begin
                ref_ack <= 0; rc <= 0;
            end
            if (m_sre || m_srx) begin
                if (sc >= sr_lat) begin
                    sr_enter_ack <= m_sre; sr_exit_ack <= m_srx; sc <= 0;
                end else begin
                    sr_enter_ack <= 0; sr_exit_ack <= 0; sc <= sc + 1;
                end
            end else begin
                sr_enter_ack <= 0; sr_exit_ack <= 0; sc <= 0;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000 && !done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    int wstamp = 0;
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d; wstamp = cyc;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_ref_rise(output int t);
        logic p;
        p = ref_req;
        @(negedge clk);
        while (!(ref_req && !p)) begin p = ref_req; @(negedge clk); end
        t = cyc;
    endtask

    initial begin
        int t0, t1, tc, ts, quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk(cfg_rdata == 32'h0000_0884, "R1 reset control word", cfg_rdata, 32'h0000_0884);
        chk(mclk_en && !ref_req && !sr_enter_req && !sr_exit_req, "R1 reset outputs",
            {ref_req, sr_enter_req, sr_exit_req, mclk_en}, 32'h1);

        // R3 reserved bits and bit 23 ignored; R6 stop bit refused without self-refresh
        wr(32'h7F80_1234);
        chk(cfg_rdata == 32'h0000_1234, "R3 R6 reserved/stop masked", cfg_rdata, 32'h0000_1234);

        // R2 floor on short intervals
        trfc = 8'h20;
        wr(32'h0000_00FF);
        chk(cfg_rdata[15:0] == 16'h0040, "R2 interval below floor", cfg_rdata, 32'h40);
        wr(32'h0000_0100);
        chk(cfg_rdata[15:0] == 16'h0100, "R2 interval at floor", cfg_rdata, 32'h100);

        // R4 period and restart on write
        wait_ref_rise(t0);
        wait_ref_rise(t1);
        chk(t1 - t0 == 256, "R4 refresh period", t1 - t0, 256);
        repeat (10) @(negedge clk);
        wr(32'h0000_0200);
        while (!ref_req) @(negedge clk);
        chk(cyc - wstamp == 513, "R4 restart after write", cyc - wstamp, 513);

        // R5 pending saturation and back-to-back issue
        repeat (10) @(negedge clk);
        wr(32'h0000_0010);
        ref_block = 1;
        repeat (700) @(negedge clk);
        chk(ref_req == 1'b1, "R5 request held without ack", 32'(ref_req), 1);
        wr(32'h0000_0010);
        acc = 0; ref_lat = 0; ref_block = 0;
        repeat (30) @(negedge clk);
        chk(acc == 8, "R5 saturated owed refreshes", acc, 8);

        // R7 R8 entry
        ref_lat = 2; sr_lat = 6;
        wr(32'h0000_0100);
        wr(32'h8000_0100);
        wr(32'hC000_0100);
        while (!sr_enter_req) @(negedge clk);
        chk(!ref_req, "R7 entry only when drained", 32'(ref_req), 0);
        chk(mclk_en, "R8 clock kept before entry ack", 32'(mclk_en), 1);
        while (sr_enter_req) @(negedge clk);
        chk(!mclk_en, "R8 clock stopped after entry ack", 32'(mclk_en), 0);
        chk(cfg_rdata == 32'hC000_0100, "R6 stop accepted in self-refresh", cfg_rdata, 32'hC000_0100);

        // R7 no refresh while in self-refresh
        quiet = 0;
        repeat (600) begin
            @(negedge clk);
            if (ref_req || sr_exit_req) quiet++;
        end
        chk(quiet == 0, "R7 no requests in self-refresh", quiet, 0);

        // R10 clock back without leaving self-refresh
        wr(32'h8000_0100);
        chk(mclk_en && !sr_exit_req, "R10 clock restored, still in SR", {sr_exit_req, mclk_en}, 32'h1);
        repeat (40) @(negedge clk);
        chk(mclk_en && !sr_exit_req && !ref_req, "R10 stays in SR", {ref_req, sr_exit_req, mclk_en}, 32'h1);

        // R9 exit sequence
        wr(32'hC000_0100);
        chk(!mclk_en, "R6 R8 clock stopped again", 32'(mclk_en), 0);
        wr(32'h4000_0100);
        while (!mclk_en) @(negedge clk);
        tc = cyc;
        chk(!sr_exit_req, "R9 clock before exit request", 32'(sr_exit_req), 0);
        while (!sr_exit_req) @(negedge clk);
        ts = cyc;
        chk(ts - tc == 16, "R9 wake wait length", ts - tc, 16);
        while (sr_exit_req) @(negedge clk);
        chk(ref_req, "R9 refresh right after exit", 32'(ref_req), 1);

        repeat (300) @(negedge clk);
        finish_run();
    end

endmodule